// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks line reservations that give load-linked / store-conditional pairs their atomicity at a data cache. It sees each completed operation as a single-cycle strobe carrying the line address, the operation kind and the requester identifier. A load-linked completion reserves its line for the requester. A later store-conditional from the same requester succeeds only if that reservation is still in place. Ordinary stores and remote invalidations can take a reservation away.

For every completion, one cycle later, the monitor returns a registered result: a valid strobe and a pass/fail bit. Only a store-conditional can fail; every other operation reports a pass. A small fully associative table holds the reservations. When the table is full, a load-linked to a new line displaces the reservation that was set earliest. A mode input turns the mechanism off. While it is off, every operation passes and completions leave the table untouched.

Top module: `llsc_rsv_monitor`

## Requirements
- R1: A load-linked completion (cmp_op = 2'b10) reserves its line for cmp_id, and a later store-conditional (cmp_op = 2'b11) from the same requester to that line reports res_ok = 1.
- R2: A store-conditional reports res_ok = 0 when its line holds no reservation, or when the reservation belongs to a different requester.
- R3: Every store-conditional removes the reservation on its line, whether it passed or failed, so a following store-conditional to that line fails.
- R4: An ordinary store (cmp_op = 2'b01) removes the reservation on its line only if that reservation belongs to the storing requester; a store from another requester leaves it in place.
- R5: Load-linked, plain load (cmp_op = 2'b00) and ordinary store completions always report res_ok = 1, and a plain load does not change any reservation.
- R6: While mon_en = 0, every completion reports res_ok = 1 and no completion changes any reservation.
- R7: Up to NUM_ENTRIES distinct lines can be reserved at once. A load-linked to an unreserved line takes a free entry if one exists, and otherwise displaces the entry whose reservation was set earliest. A load-linked to a line that is already reserved only changes the owner and keeps the entry's age.
- R8: An invalidate (inv_vld) removes any reservation on inv_addr. It takes effect before a completion in the same cycle: a load-linked to the same line still reserves it, and a store-conditional to the same line fails.
- R9: res_vld is high exactly in the cycle after a cycle with cmp_vld high, and res_ok is meaningful in that cycle.
- R10: After reset, no line is reserved and res_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | 1 = reservations tracked; 0 = bypass, all pass |
| cmp_vld | input | 1 | Completion strobe |
| cmp_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| cmp_addr | input | LINE_AW | Line address of the completion |
| cmp_id | input | ID_W | Requester identifier of the completion |
| inv_vld | input | 1 | Remote invalidate strobe |
| inv_addr | input | LINE_AW | Line address being invalidated |
| res_vld | output | 1 | Result valid, one cycle after cmp_vld |
| res_ok | output | 1 | 1 = pass, 0 = store-conditional failed |

## Verification
The embedded assertions check on every cycle:
- the one-cycle result timing;
- the forced pass for non-conditional operations and in bypass mode;
- that a store-conditional or invalidate leaves no entry on its line;
- that no line is held twice;
- that valid entries carry distinct age ranks.

Which entry is displaced when the table fills is a matter of history, and so is whether a store by another requester, a retag or a same-cycle invalidate gives the right later outcome. Only the bench's directed sequences can show these, by reading later store-conditional results.

// File: rtl/llsc_rsv_pkg.sv
package llsc_rsv_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LL    = 2'b10,
      OP_SC    = 2'b11
   } rsv_op_e;
endpackage

// File: rtl/llsc_rsv_pick.sv
module llsc_rsv_pick #(
   parameter int NUM_ENTRIES = 4
) (
   input  logic [NUM_ENTRIES-1:0] busy,
   output logic [NUM_ENTRIES-1:0] free_oh,
   output logic                   any_free
);
   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (!busy[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end
   assign any_free = ~&busy;
endmodule

// File: rtl/llsc_rsv_age.sv
module llsc_rsv_age #(
   parameter int NUM_ENTRIES = 4,
   localparam int RW = $clog2(NUM_ENTRIES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_ENTRIES-1:0] valid_q,
   input  logic [NUM_ENTRIES-1:0] valid_d,
   input  logic [NUM_ENTRIES-1:0] removed,
   input  logic [NUM_ENTRIES-1:0] alloc_oh,
   output logic [NUM_ENTRIES-1:0] oldest_oh
);
   logic [RW-1:0] rank_q [NUM_ENTRIES];
   logic [RW-1:0] rank_d [NUM_ENTRIES];
   logic [RW-1:0] below  [NUM_ENTRIES];
   logic          any_alloc;

   assign any_alloc = |alloc_oh;

   always_comb begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         below[i] = '0;
         for (int j = 0; j < NUM_ENTRIES; j++) begin
            if (removed[j] && (rank_q[j] < rank_q[i])) below[i] = below[i] + 1'b1;
         end
         if (alloc_oh[i])     rank_d[i] = '0;
         else if (valid_d[i]) rank_d[i] = rank_q[i] - below[i] + RW'(any_alloc);
         else                 rank_d[i] = '0;
      end
   end

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_rank
      always_ff @(posedge clk) begin
         if (!rst_n) rank_q[i] <= '0;
         else        rank_q[i] <= rank_d[i];
      end
      assign oldest_oh[i] = valid_q[i] && (rank_q[i] == RW'(NUM_ENTRIES - 1));

      for (genvar j = i + 1; j < NUM_ENTRIES; j++) begin : g_pair
         AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
            !(valid_q[i] && valid_q[j] && rank_q[i] == rank_q[j])); // R7
      end
   end

   AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oldest_oh)); // R7
endmodule

// File: rtl/llsc_rsv_monitor.sv
module llsc_rsv_monitor #(
   parameter int LINE_AW     = 26,
   parameter int ID_W        = 4,
   parameter int NUM_ENTRIES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mon_en,
   input  logic               cmp_vld,
   input  logic [1:0]         cmp_op,
   input  logic [LINE_AW-1:0] cmp_addr,
   input  logic [ID_W-1:0]    cmp_id,
   input  logic               inv_vld,
   input  logic [LINE_AW-1:0] inv_addr,
   output logic               res_vld,
   output logic               res_ok
);
   import llsc_rsv_pkg::*;

   if (NUM_ENTRIES < 2 || (NUM_ENTRIES & (NUM_ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two of at least 2");
   end
   if (LINE_AW < 1 || ID_W < 1) begin : g_bad_width
      $error("LINE_AW and ID_W must be positive");
   end

   logic [NUM_ENTRIES-1:0] valid_q, valid_d, valid_pi;
   logic [LINE_AW-1:0]     addr_q [NUM_ENTRIES];
   logic [ID_W-1:0]        id_q   [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] hit, id_hit, clr_cmp, retag, removed;
   logic [NUM_ENTRIES-1:0] free_oh, oldest_oh, alloc_oh;
   logic                   any_free, act, need_alloc, sc_pass;
   rsv_op_e                op;
   logic                   res_vld_q, res_ok_q;

   assign op  = rsv_op_e'(cmp_op);
   assign act = cmp_vld && mon_en;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      assign valid_pi[i] = valid_q[i] && !(inv_vld && addr_q[i] == inv_addr);
      assign hit[i]      = valid_pi[i] && (addr_q[i] == cmp_addr);
      assign id_hit[i]   = hit[i] && (id_q[i] == cmp_id);
      assign clr_cmp[i]  = act && (((op == OP_SC) && hit[i]) ||
                                   ((op == OP_STORE) && id_hit[i]));
      assign retag[i]    = act && (op == OP_LL) && hit[i];
      assign valid_d[i]  = (valid_pi[i] && !clr_cmp[i]) || alloc_oh[i];
      assign removed[i]  = valid_q[i] && (!valid_pi[i] || clr_cmp[i] || alloc_oh[i]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
            addr_q[i]  <= '0;
            id_q[i]    <= '0;
         end else begin
            valid_q[i] <= valid_d[i];
            if (alloc_oh[i]) begin
               addr_q[i] <= cmp_addr;
               id_q[i]   <= cmp_id;
            end else if (retag[i]) begin
               id_q[i] <= cmp_id;
            end
         end
      end

      AST_SC_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         (act && op == OP_SC) |=> !(valid_q[i] && addr_q[i] == $past(cmp_addr))); // R3
      AST_INV_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         (inv_vld && !(act && op == OP_LL && cmp_addr == inv_addr))
         |=> !(valid_q[i] && addr_q[i] == $past(inv_addr))); // R8

      for (genvar j = i + 1; j < NUM_ENTRIES; j++) begin : g_pair
         AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
            !(valid_q[i] && valid_q[j] && addr_q[i] == addr_q[j])); // R7
      end
   end

   assign need_alloc = act && (op == OP_LL) && !(|hit);
   assign alloc_oh   = !need_alloc ? '0 : (any_free ? free_oh : oldest_oh);
   assign sc_pass    = |id_hit;

   llsc_rsv_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
      .busy     (valid_pi),
      .free_oh  (free_oh),
      .any_free (any_free)
   );

   llsc_rsv_age #(.NUM_ENTRIES(NUM_ENTRIES)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_q   (valid_q),
      .valid_d   (valid_d),
      .removed   (removed),
      .alloc_oh  (alloc_oh),
      .oldest_oh (oldest_oh)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld_q <= 1'b0;
         res_ok_q  <= 1'b0;
      end else begin
         res_vld_q <= cmp_vld;
         res_ok_q  <= !(act && op == OP_SC) || sc_pass;
      end
   end

   assign res_vld = res_vld_q;
   assign res_ok  = res_ok_q;

   AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_vld |=> res_vld); // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_vld |=> !res_vld); // R9
   AST_NON_SC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld && cmp_op != 2'b11) |=> res_ok); // R5
   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld && !mon_en) |=> res_ok); // R6
   AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_en && !inv_vld) |=> $stable(valid_q)); // R6
endmodule

// File: tb/tb_llsc_rsv_monitor.sv
module tb_llsc_rsv_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 26;
   localparam int IW = 4;
   localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

   logic clk = 1'b0, rst_n = 1'b0, mon_en = 1'b1;
   logic cmp_vld = 1'b0, inv_vld = 1'b0;
   logic [1:0] cmp_op = '0;
   logic [AW-1:0] cmp_addr = '0, inv_addr = '0;
   logic [IW-1:0] cmp_id = '0;
   logic res_vld, res_ok;
   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   llsc_rsv_monitor #(.LINE_AW(AW), .ID_W(IW), .NUM_ENTRIES(4)) dut (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .cmp_vld(cmp_vld), .cmp_op(cmp_op),
      .cmp_addr(cmp_addr), .cmp_id(cmp_id), .inv_vld(inv_vld), .inv_addr(inv_addr),
      .res_vld(res_vld), .res_ok(res_ok));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // One completion, optionally with an invalidate in the same cycle.
   task automatic op_inv(input logic [1:0] op, input logic [AW-1:0] a, input logic [IW-1:0] id,
                         input logic iv, input logic [AW-1:0] ia,
                         input logic exp_ok, input string tag);
      @(negedge clk);
      cmp_vld = 1'b1; cmp_op = op; cmp_addr = a; cmp_id = id;
      inv_vld = iv; inv_addr = ia;
      @(negedge clk);
      cmp_vld = 1'b0; inv_vld = 1'b0;
      chk({tag, " res_vld"}, res_vld, 1'b1);
      chk(tag, res_ok, exp_ok);
   endtask

   task automatic op1(input logic [1:0] op, input logic [AW-1:0] a, input logic [IW-1:0] id,
                      input logic exp_ok, input string tag);
      op_inv(op, a, id, 1'b0, '0, exp_ok, tag);
   endtask

   task automatic inv_only(input logic [AW-1:0] a);
      @(negedge clk);
      inv_vld = 1'b1; inv_addr = a;
      @(negedge clk);
      inv_vld = 1'b0;
   endtask

   task automatic t_reset;
      chk("R10 res_vld after reset", res_vld, 1'b0);
      op1(SC, 26'h10, 4'd1, 1'b0, "R10 no reservation after reset");
      @(negedge clk);
      chk("R9 res_vld drops after idle cycle", res_vld, 1'b0);
   endtask

   task automatic t_basic;
      op1(LL, 26'h20, 4'd1, 1'b1, "R5 LL passes");
      op1(SC, 26'h20, 4'd1, 1'b1, "R1 SC after LL");
      op1(SC, 26'h20, 4'd1, 1'b0, "R3 second SC fails");
      op1(LL, 26'h21, 4'd1, 1'b1, "R5 LL passes");
      op1(SC, 26'h21, 4'd2, 1'b0, "R2 SC by other id fails");
      op1(SC, 26'h21, 4'd1, 1'b0, "R3 failed SC cleared line");
      op1(SC, 26'h22, 4'd1, 1'b0, "R2 SC to unreserved line");
   endtask

   task automatic t_store;
      op1(LL, 26'h30, 4'd1, 1'b1, "R5 LL passes");
      op1(ST, 26'h30, 4'd2, 1'b1, "R5 store passes");
      op1(LD, 26'h30, 4'd1, 1'b1, "R5 load passes");
      op1(SC, 26'h30, 4'd1, 1'b1, "R4 other-id store and load keep reservation");
      op1(LL, 26'h31, 4'd1, 1'b1, "R5 LL passes");
      op1(ST, 26'h31, 4'd1, 1'b1, "R5 store passes");
      op1(SC, 26'h31, 4'd1, 1'b0, "R4 owner store clears reservation");
   endtask

   task automatic t_retag;
      op1(LL, 26'h40, 4'd1, 1'b1, "R5 LL passes");
      op1(LL, 26'h40, 4'd2, 1'b1, "R5 LL passes");
      op1(SC, 26'h40, 4'd2, 1'b1, "R7 retag to new owner");
   endtask

   task automatic t_evict;
      for (int k = 0; k < 4; k++) op1(LL, 26'h50 + 26'(k), 4'd3, 1'b1, "R5 LL passes");
      op1(LL, 26'h54, 4'd3, 1'b1, "R5 LL passes");
      op1(SC, 26'h50, 4'd3, 1'b0, "R7 oldest displaced");
      for (int k = 1; k < 5; k++) op1(SC, 26'h50 + 26'(k), 4'd3, 1'b1, "R7 newer kept");
      // retag does not refresh age
      for (int k = 0; k < 4; k++) op1(LL, 26'h60 + 26'(k), 4'd3, 1'b1, "R5 LL passes");
      op1(LL, 26'h60, 4'd4, 1'b1, "R5 LL passes");
      op1(LL, 26'h64, 4'd3, 1'b1, "R5 LL passes");
      op1(SC, 26'h60, 4'd4, 1'b0, "R7 retagged entry keeps its age");
      op1(SC, 26'h61, 4'd3, 1'b1, "R7 second oldest kept");
      op1(SC, 26'h62, 4'd3, 1'b1, "R7 kept");
      op1(SC, 26'h63, 4'd3, 1'b1, "R7 kept");
      op1(SC, 26'h64, 4'd3, 1'b1, "R7 kept");
      // free slot reused before any displacement
      for (int k = 0; k < 4; k++) op1(LL, 26'h70 + 26'(k), 4'd3, 1'b1, "R5 LL passes");
      op1(SC, 26'h71, 4'd3, 1'b1, "R1 SC middle entry");
      op1(LL, 26'h74, 4'd3, 1'b1, "R5 LL passes");
      op1(LL, 26'h75, 4'd3, 1'b1, "R5 LL passes");
      op1(SC, 26'h70, 4'd3, 1'b0, "R7 oldest displaced after reuse");
      op1(SC, 26'h72, 4'd3, 1'b1, "R7 kept");
      op1(SC, 26'h73, 4'd3, 1'b1, "R7 kept");
      op1(SC, 26'h74, 4'd3, 1'b1, "R7 free slot used");
      op1(SC, 26'h75, 4'd3, 1'b1, "R7 kept");
   endtask

   task automatic t_inv;
      op1(LL, 26'h80, 4'd1, 1'b1, "R5 LL passes");
      inv_only(26'h80);
      op1(SC, 26'h80, 4'd1, 1'b0, "R8 invalidate clears");
      op1(LL, 26'h81, 4'd1, 1'b1, "R5 LL passes");
      inv_only(26'h99);
      op1(SC, 26'h81, 4'd1, 1'b1, "R8 other-line invalidate harmless");
      op_inv(LL, 26'h82, 4'd1, 1'b1, 26'h82, 1'b1, "R8 LL with same-cycle invalidate");
      op1(SC, 26'h82, 4'd1, 1'b1, "R8 LL wins over same-cycle invalidate");
      op1(LL, 26'h83, 4'd1, 1'b1, "R5 LL passes");
      op_inv(SC, 26'h83, 4'd1, 1'b1, 26'h83, 1'b0, "R8 SC with same-cycle invalidate fails");
   endtask

   task automatic t_bypass;
      op1(LL, 26'h90, 4'd1, 1'b1, "R5 LL passes");
      mon_en = 1'b0;
      op1(SC, 26'h91, 4'd1, 1'b1, "R6 bypass SC passes");
      op1(LL, 26'h92, 4'd1, 1'b1, "R6 bypass LL passes");
      op1(SC, 26'h90, 4'd2, 1'b1, "R6 bypass SC passes");
      op1(ST, 26'h90, 4'd1, 1'b1, "R6 bypass store passes");
      mon_en = 1'b1;
      op1(SC, 26'h92, 4'd1, 1'b0, "R6 bypass LL set nothing");
      op1(SC, 26'h90, 4'd1, 1'b1, "R6 bypass ops left reservation");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_store();
      t_retag();
      t_evict();
      t_inv();
      t_bypass();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule